// File: doc/BRIEF.md
# Sleep Mode Entry Controller

This block governs a low-power retention state for a synchronous memory. A request line arrives from outside the clock domain, is resynchronised, and then drives a four-phase controller: awake, entering, asleep and recovering. Entry and exit each take a fixed number of clock cycles. While any phase other than awake is active, the block holds a blocking indication that forces the read and write enables of the storage core low. Stored contents are therefore retained, and any access that was in flight when entry began is dropped.

The block also checks how the surrounding system uses the memory around the sleep state. A violation is flagged when the memory is still fully selected at the moment entry begins. A violation is also flagged when any chip select or address strobe is driven active while recovery is running. The three chip selects use mixed polarity: select 0 and select 2 are active low and select 1 is active high. Both address strobes are active low.

Top module: `sleep_mode_ctrl`

## Requirements
- R1: `zz_async` passes through `SYNC_STAGES` reset-cleared flops. When it is held high, `access_block` first reads high after the (`SYNC_STAGES`+1)-th rising edge and still reads low after the `SYNC_STAGES`-th edge.
- R2: `sleep_active` rises exactly `ENTRY_CYCLES` rising edges after `access_block` rises.
- R3: Once `zz_async` is held low while asleep, `sleep_active` falls at the (`SYNC_STAGES`+1)-th edge. `access_block` falls `EXIT_CYCLES` edges after that.
- R4: While `access_block` is low, `core_rd_en` equals `core_rd_req` and `core_wr_en` equals `core_wr_req`. While `access_block` is high, both enables are low.
- R5: At the edge where entry begins, if `cs0_n`=0, `cs1`=1 and `cs2_n`=0 all hold, `violation` reads high for exactly the following cycle. Otherwise it stays low.
- R6: At each edge sampled during recovery, if `cs0_n`=0, `cs1`=1, `cs2_n`=0, `astb_a_n`=0 or `astb_b_n`=0, `violation` reads high in the following cycle.
- R7: Select and strobe activity while awake (other than at entry start), while entering, or while asleep never raises `violation`.
- R8: An active-low `rst_n` immediately returns the block to awake, with `sleep_active`, `access_block` and `violation` low, even in the middle of sleep.
- R9: `sleep_active` is never high while `access_block` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zz_async | input | 1 | Sleep request, asynchronous to clk |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1 | input | 1 | Chip select 1, active high |
| cs2_n | input | 1 | Chip select 2, active low |
| astb_a_n | input | 1 | Address strobe A, active low |
| astb_b_n | input | 1 | Address strobe B, active low |
| core_rd_req | input | 1 | Core read enable request |
| core_wr_req | input | 1 | Core write enable request |
| sleep_active | output | 1 | Block is in the retained sleep phase |
| access_block | output | 1 | Core accesses suppressed (entry, sleep, recovery) |
| violation | output | 1 | One-cycle protocol violation pulse |
| core_rd_en | output | 1 | Gated core read enable |
| core_wr_en | output | 1 | Gated core write enable |

## Verification
The bench builds the block with two synchroniser stages, an entry latency of three cycles and an exit latency of two. Making the entry and exit latencies unequal exposes any swap between the two counter loads, and it separates the entry check from the synchroniser delay. With only five select/strobe lines, every one of the 32 patterns at entry start can be crossed with every one of the 32 patterns during recovery. This covers the all-three-selected corner, each single active line, and the mixed polarities, while the bench recomputes edge positions from the three parameters.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
  typedef enum logic [1:0] {
    PH_AWAKE   = 2'd0,
    PH_ENTER   = 2'd1,
    PH_ASLEEP  = 2'd2,
    PH_RECOVER = 2'd3
  } sleep_phase_e;

  // True when every chip select is in its active level (mixed polarity).
  function automatic logic fully_selected(input logic cs0_n, input logic cs1,
                                          input logic cs2_n);
    return !cs0_n && cs1 && !cs2_n;
  endfunction

  // True when any select or strobe is in its active level.
  function automatic logic any_activity(input logic cs0_n, input logic cs1,
                                        input logic cs2_n, input logic stb_a_n,
                                        input logic stb_b_n);
    return !cs0_n || cs1 || !cs2_n || !stb_a_n || !stb_b_n;
  endfunction

  // Counter width able to hold values 0 .. n-1.
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/zz_synchronizer.sv
module zz_synchronizer #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sleep_phase_fsm.sv
module sleep_phase_fsm
  import sleep_ctl_pkg::*;
#(
  parameter int unsigned ENTRY_CYCLES = 2,
  parameter int unsigned EXIT_CYCLES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zz_sync,
  output sleep_phase_e phase,
  output logic         entry_start,
  output logic         in_recover
);
  localparam int unsigned LONGEST = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int unsigned CNT_W   = count_width(LONGEST);
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

  sleep_phase_e     phase_q;
  logic [CNT_W-1:0] left_q;
  logic             left_zero;

  assign left_zero   = (left_q == '0);
  assign entry_start = (phase_q == PH_AWAKE) && zz_sync;
  assign in_recover  = (phase_q == PH_RECOVER);
  assign phase       = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AWAKE;
      left_q  <= '0;
    end else begin
      case (phase_q)
        PH_AWAKE: begin
          if (zz_sync) begin
            phase_q <= PH_ENTER;
            left_q  <= ENTRY_LOAD;
          end
        end
        PH_ENTER: begin
          if (left_zero) phase_q <= PH_ASLEEP;
          else           left_q  <= left_q - CNT_W'(1);
        end
        PH_ASLEEP: begin
          if (!zz_sync) begin
            phase_q <= PH_RECOVER;
            left_q  <= EXIT_LOAD;
          end
        end
        PH_RECOVER: begin
          if (left_zero) phase_q <= PH_AWAKE;
          else           left_q  <= left_q - CNT_W'(1);
        end
        default: phase_q <= PH_AWAKE;
      endcase
    end
  end
endmodule

// File: rtl/violation_monitor.sv
module violation_monitor
  import sleep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic entry_start,
  input  logic in_recover,
  input  logic cs0_n,
  input  logic cs1,
  input  logic cs2_n,
  input  logic astb_a_n,
  input  logic astb_b_n,
  output logic violation
);
  logic selected_at_entry;
  logic busy_in_recover;

  assign selected_at_entry = entry_start && fully_selected(cs0_n, cs1, cs2_n);
  assign busy_in_recover   = in_recover &&
                             any_activity(cs0_n, cs1, cs2_n, astb_a_n, astb_b_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= selected_at_entry || busy_in_recover;
  end
endmodule

// File: rtl/sleep_mode_ctrl.sv
module sleep_mode_ctrl
  import sleep_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned ENTRY_CYCLES = 2,
  parameter int unsigned EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zz_async,
  input  logic cs0_n,
  input  logic cs1,
  input  logic cs2_n,
  input  logic astb_a_n,
  input  logic astb_b_n,
  input  logic core_rd_req,
  input  logic core_wr_req,
  output logic sleep_active,
  output logic access_block,
  output logic violation,
  output logic core_rd_en,
  output logic core_wr_en
);
  logic         zz_sync;
  logic         entry_start;
  logic         in_recover;
  sleep_phase_e phase;

  zz_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (zz_async),
    .sync_out (zz_sync)
  );

  sleep_phase_fsm #(
    .ENTRY_CYCLES (ENTRY_CYCLES),
    .EXIT_CYCLES  (EXIT_CYCLES)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .zz_sync     (zz_sync),
    .phase       (phase),
    .entry_start (entry_start),
    .in_recover  (in_recover)
  );

  violation_monitor u_viol (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_start (entry_start),
    .in_recover  (in_recover),
    .cs0_n       (cs0_n),
    .cs1         (cs1),
    .cs2_n       (cs2_n),
    .astb_a_n    (astb_a_n),
    .astb_b_n    (astb_b_n),
    .violation   (violation)
  );

  assign sleep_active = (phase == PH_ASLEEP);
  assign access_block = (phase != PH_AWAKE);
  assign core_rd_en   = core_rd_req && !access_block;
  assign core_wr_en   = core_wr_req && !access_block;
endmodule

// File: rtl/sleep_ctl_checks.sv
module sleep_ctl_checks (
  input logic clk,
  input logic rst_n,
  input logic zz_sync,
  input logic entry_start,
  input logic in_recover,
  input logic sleep_active,
  input logic access_block,
  input logic violation,
  input logic core_rd_en,
  input logic core_wr_en
);
  // R9
  sleep_implies_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> access_block);

  // R4
  blocked_enables_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_block |-> !(core_rd_en || core_wr_en));

  // R1
  block_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_block) |-> $past(zz_sync));

  // R2
  sleep_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(access_block));

  // R3
  unblock_after_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_block) |-> ($past(in_recover) && !sleep_active));

  // R6
  violation_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(entry_start || in_recover));
endmodule

bind sleep_mode_ctrl sleep_ctl_checks u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .zz_sync      (zz_sync),
  .entry_start  (entry_start),
  .in_recover   (in_recover),
  .sleep_active (sleep_active),
  .access_block (access_block),
  .violation    (violation),
  .core_rd_en   (core_rd_en),
  .core_wr_en   (core_wr_en)
);

// File: tb/sleep_mode_ctrl_test.sv
`timescale 1ns/1ps
module sleep_mode_ctrl_test;
  localparam int unsigned SYNC  = 2;
  localparam int unsigned ENTRY = 3;
  localparam int unsigned EXIT  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zz_async = 1'b0;
  logic cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1, astb_a_n = 1'b1, astb_b_n = 1'b1;
  logic core_rd_req = 1'b0, core_wr_req = 1'b0;
  logic sleep_active, access_block, violation, core_rd_en, core_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sleep_mode_ctrl #(
    .SYNC_STAGES  (SYNC),
    .ENTRY_CYCLES (ENTRY),
    .EXIT_CYCLES  (EXIT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .zz_async(zz_async),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .astb_a_n(astb_a_n), .astb_b_n(astb_b_n),
    .core_rd_req(core_rd_req), .core_wr_req(core_wr_req),
    .sleep_active(sleep_active), .access_block(access_block),
    .violation(violation), .core_rd_en(core_rd_en), .core_wr_en(core_wr_en)
  );

  task automatic check(input string req, input string what,
                       input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, actual, expected, $time);
    end
  endtask

  // pattern bits: 0 sel0 active, 1 sel1 active, 2 sel2 active, 3 strobe A, 4 strobe B
  task automatic drive_pat(input logic [4:0] p);
    cs0_n    = ~p[0];
    cs1      =  p[1];
    cs2_n    = ~p[2];
    astb_a_n = ~p[3];
    astb_b_n = ~p[4];
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleep_round(input logic [4:0] ep, input logic [4:0] rp);
    core_rd_req = 1'b1;
    core_wr_req = 1'b1;
    drive_pat(ep);
    zz_async = 1'b1;
    step(SYNC);
    check("R1", "block before sync done", access_block, 1'b0);
    check("R7", "no flag while awake", violation, 1'b0);
    check("R4", "rd passes while awake", core_rd_en, 1'b1);
    step(1);
    check("R1", "block after sync+1", access_block, 1'b1);
    check("R5", "entry flag", violation, &ep[2:0]);
    check("R4", "rd gated", core_rd_en, 1'b0);
    drive_pat(5'h00);
    step(1);
    check("R5", "entry flag one cycle", violation, 1'b0);
    step(ENTRY - 2);
    check("R2", "not asleep before entry latency", sleep_active, 1'b0);
    step(1);
    check("R2", "asleep after entry latency", sleep_active, 1'b1);
    drive_pat(5'h1f);
    step(2);
    check("R7", "no flag while asleep", violation, 1'b0);
    check("R4", "wr gated while asleep", core_wr_en, 1'b0);
    drive_pat(5'h00);
    zz_async = 1'b0;
    step(SYNC);
    check("R3", "still asleep during sync", sleep_active, 1'b1);
    step(1);
    check("R3", "sleep ends at sync+1", sleep_active, 1'b0);
    check("R3", "block held in recovery", access_block, 1'b1);
    drive_pat(rp);
    step(1);
    check("R6", "recovery flag first", violation, |rp);
    check("R3", "block held to exit latency", access_block, 1'b1);
    step(EXIT - 1);
    check("R3", "block released", access_block, 1'b0);
    check("R6", "recovery flag last", violation, |rp);
    check("R4", "wr passes after release", core_wr_en, 1'b1);
    drive_pat(5'h00);
    step(1);
    check("R7", "no flag after recovery", violation, 1'b0);
  endtask

  initial begin
    drive_pat(5'h1f);
    zz_async = 1'b1;
    core_rd_req = 1'b1;
    step(3);
    check("R8", "reset sleep", sleep_active, 1'b0);
    check("R8", "reset block", access_block, 1'b0);
    check("R8", "reset flag", violation, 1'b0);
    zz_async = 1'b0;
    drive_pat(5'h00);
    step(SYNC + 1);
    rst_n = 1'b1;
    step(2);
    drive_pat(5'h1f);
    step(3);
    check("R7", "awake activity ignored", violation, 1'b0);
    check("R4", "awake rd passes", core_rd_en, 1'b1);
    drive_pat(5'h00);
    step(1);

    for (int e = 0; e < 32; e++) begin
      for (int r = 0; r < 32; r++) begin
        sleep_round(5'(e), 5'(r));
      end
    end

    zz_async = 1'b1;
    step(SYNC + 1 + ENTRY + 2);
    check("R2", "asleep before mid reset", sleep_active, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R8", "mid reset sleep", sleep_active, 1'b0);
    check("R8", "mid reset block", access_block, 1'b0);
    check("R8", "mid reset flag", violation, 1'b0);
    zz_async = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(SYNC + 2);
    check("R8", "awake after reset release", access_block, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule